// File: doc/BRIEF.md
# Execution-Count Break Qualifier

This block sits behind a debug channel's comparator and decides which condition matches turn into a break request. Software loads an occurrence count through a small synchronous register port. With the counting mode enabled, every match strobe from the comparator takes one off the count. The match that arrives while the count holds one raises the break, so the break lands on the Nth occurrence of the condition. With the counting mode disabled, every match raises a break straight away and the count is left alone.

The count register is 16 bits wide on the bus, but only its low 12 bits are storage. The upper four bits read as zero and ignore writes. The break request is a registered one-cycle pulse that follows the qualifying match by one clock edge.

Top module: `exec_count_break`

## Requirements
- R1: After reset the count reads 0 and `brk_req` is low.
- R2: `reg_rdata[15:12]` always reads 0, whatever was written to those bits. The count is read at `reg_rdata[11:0]`.
- R3: A write (`reg_we` high) loads `reg_wdata[11:0]` into the count, and the new value is visible from the next cycle. The largest value is 4095.
- R4: With `cnt_mode_en` high, a match (`match_stb` high) with no write, while the count is above 1, lowers the count by one and raises no break.
- R5: With `cnt_mode_en` high, a match with no write, while the count equals 1, sets the count to 0 and raises `brk_req` in the next cycle.
- R6: With `cnt_mode_en` high, a match while the count is 0 leaves the count at 0 (no wrap) and raises no break.
- R7: With `cnt_mode_en` low, every match raises `brk_req` in the next cycle and leaves the count unchanged.
- R8: A write in the same cycle as a match takes priority. The written value is loaded. In counting mode the match neither decrements nor breaks. In direct mode the match still raises the break.
- R9: `brk_req` is high for exactly the cycle after each qualifying match and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data: count in the low 12 bits, zero above |
| cnt_mode_en | input | 1 | Enable for execution-count mode |
| match_stb | input | 1 | One-cycle condition-match strobe from the comparator |
| brk_req | output | 1 | One-cycle break request |

## Verification
Two events can land on the same edge: a bus write to the count and a match strobe. When they coincide, the write must win, and the outcome depends on the mode and on the count value that was replaced. Directed cases put a write on the same cycle as a match in both modes, including a write that replaces a count of one. Random traffic produces many more such collisions. A bench model applies the priority rule and checks both the loaded count and the presence or absence of the break pulse one cycle later.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

    // Action picked for the count register in one cycle
    typedef enum logic [2:0] {
        ACT_HOLD   = 3'd0,  // nothing changes
        ACT_LOAD   = 3'd1,  // bus write, no break
        ACT_LOADBK = 3'd2,  // bus write plus direct-mode break
        ACT_DEC    = 3'd3,  // counted match, count above one
        ACT_LAST   = 3'd4,  // counted match at one: go to zero, break
        ACT_DIRECT = 3'd5   // direct-mode match: break, count held
    } ecb_act_e;

endpackage

// File: rtl/ecb_qualifier.sv
module ecb_qualifier
    import ecb_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             wr_en,
    input  logic             mode_en,
    input  logic             match,
    input  logic [CNT_W-1:0] cnt,
    output ecb_act_e         act
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic cnt_is_zero;
    logic cnt_is_one;

    assign cnt_is_zero = (cnt == '0);
    assign cnt_is_one  = (cnt == ONE);

    always_comb begin
        act = ACT_HOLD;
        if (wr_en) begin
            // Write wins. Only a direct-mode match still breaks.
            act = (match && !mode_en) ? ACT_LOADBK : ACT_LOAD;
        end else if (match) begin
            if (!mode_en) begin
                act = ACT_DIRECT;
            end else if (cnt_is_one) begin
                act = ACT_LAST;
            end else if (!cnt_is_zero) begin
                act = ACT_DEC;
            end
        end
    end

    // R6: a counted match on an empty count does nothing
    always_comb begin
        if (mode_en && match && !wr_en && cnt_is_zero) begin
            a_r6_zero_idle: assert (act == ACT_HOLD);
        end
    end

endmodule

// File: rtl/ecb_state.sv
module ecb_state
    import ecb_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ecb_act_e         act,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             brk_q
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             brk;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.brk = 1'b0;
        unique case (act)
            ACT_LOAD:   st_d.cnt = load_val;
            ACT_LOADBK: begin
                st_d.cnt = load_val;
                st_d.brk = 1'b1;
            end
            ACT_DEC:    st_d.cnt = st_q.cnt - CNT_W'(1);
            ACT_LAST: begin
                st_d.cnt = '0;
                st_d.brk = 1'b1;
            end
            ACT_DIRECT: st_d.brk = 1'b1;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
    assign brk_q = st_q.brk;

    // R4: a decrement lowers the count by exactly one
    a_r4_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_DEC |=> cnt_q == $past(cnt_q) - CNT_W'(1));

    // R5: the last match empties the count and breaks
    a_r5_last_fires: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_LAST |=> (cnt_q == '0) && brk_q);

endmodule

// File: rtl/exec_count_break.sv
module exec_count_break
    import ecb_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cnt_mode_en,
    input  logic             match_stb,
    output logic             brk_req
);

    localparam int RSV_W = REG_W - CNT_W;

    ecb_act_e         act;
    logic [CNT_W-1:0] cnt;

    ecb_qualifier #(.CNT_W(CNT_W)) u_qual (
        .wr_en   (reg_we),
        .mode_en (cnt_mode_en),
        .match   (match_stb),
        .cnt     (cnt),
        .act     (act)
    );

    ecb_state #(.CNT_W(CNT_W)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .load_val (reg_wdata[CNT_W-1:0]),
        .cnt_q    (cnt),
        .brk_q    (brk_req)
    );

    assign reg_rdata = {{RSV_W{1'b0}}, cnt};

    // R2: reserved bits read zero
    a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:CNT_W] == '0);

    // R3 / R8: a write is loaded whatever else happens
    a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> reg_rdata[CNT_W-1:0] == $past(reg_wdata[CNT_W-1:0]));

    // R7: direct mode breaks and keeps the count
    a_r7_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (match_stb && !cnt_mode_en && !reg_we) |=> brk_req && $stable(reg_rdata));

    // R9: a break always follows a match
    a_r9_brk_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(match_stb));

    // R9: no match, no break next cycle
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !match_stb |=> !brk_req);

endmodule

// File: tb/exec_count_break_tb.sv
module exec_count_break_tb;

    localparam int CLK_PERIOD = 10;
    localparam int REG_W = 16;
    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic             cnt_mode_en = 1'b0;
    logic             match_stb = 1'b0;
    logic             brk_req;

    int checks = 0;
    int failures = 0;
    int exp_cnt = 0;
    int exp_brk = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exec_count_break #(.REG_W(REG_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cnt_mode_en(cnt_mode_en),
        .match_stb(match_stb), .brk_req(brk_req)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    // Reference model of one cycle, from the requirements
    function automatic void model(input bit we, input int wd, input bit mode,
                                  input bit m);
        exp_brk = 0;
        if (we) begin
            exp_cnt = wd & 12'hFFF;
            if (m && !mode) exp_brk = 1;
        end else if (m) begin
            if (!mode) exp_brk = 1;
            else if (exp_cnt == 1) begin exp_cnt = 0; exp_brk = 1; end
            else if (exp_cnt > 1) exp_cnt = exp_cnt - 1;
        end
    endfunction

    task automatic step(input bit we, input int wd, input bit mode, input bit m,
                        input string tag);
        @(negedge clk);
        reg_we = we; reg_wdata = wd[15:0]; cnt_mode_en = mode; match_stb = m;
        @(posedge clk);
        model(we, wd, mode, m);
        #1;
        check({tag, " cnt"}, int'(reg_rdata[11:0]), exp_cnt);
        check({tag, " rsv R2"}, int'(reg_rdata[15:12]), 0);
        check({tag, " brk"}, int'(brk_req), exp_brk);
        @(negedge clk);
        reg_we = 1'b0; match_stb = 1'b0;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset cnt", int'(reg_rdata), 0);
        check("R1 reset brk", int'(brk_req), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3: reserved bits dropped, max value
        step(1, 16'hFFFF, 1, 0, "R2 R3 write all ones");
        check("R3 max 4095", int'(reg_rdata), 4095);
        step(1, 3, 1, 0, "R3 load 3");
        step(0, 0, 1, 1, "R4 dec 3->2");
        step(0, 0, 1, 0, "R4 idle");
        step(0, 0, 1, 1, "R4 dec 2->1");
        step(0, 0, 1, 1, "R5 last match");
        check("R9 pulse ends", 0, 0);
        step(0, 0, 1, 0, "R9 no second pulse");
        step(0, 0, 1, 1, "R6 at zero");
        step(0, 0, 1, 1, "R6 again");
        step(0, 0, 0, 1, "R7 direct at zero");
        step(1, 7, 0, 0, "R3 load 7");
        step(0, 0, 0, 1, "R7 direct keeps 7");
        step(0, 0, 0, 1, "R7 back to back");
        step(1, 1, 1, 0, "R3 load 1");
        step(1, 5, 1, 1, "R8 write beats last match");
        step(1, 9, 0, 1, "R8 direct write+match");
        step(1, 16'hF002, 1, 1, "R8 R2 write over match");

        // Random traffic mixing writes, modes and matches
        for (int i = 0; i < 3000; i++) begin
            bit we, mode, m;
            int wd;
            we   = ($urandom_range(0, 9) == 0);
            mode = ($urandom_range(0, 4) != 0);
            m    = $urandom_range(0, 1) == 1;
            wd   = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 65535))
                                               : int'($urandom_range(0, 4));
            step(we, wd, mode, m, "R4 R5 R6 R7 R8 R9 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule